// File: doc/BRIEF.md
# Big-Endian Byte and Word Load/Store Unit

This block connects a 32-bit register datapath to a byte-addressed data memory. The memory is organised in words and has one write enable per byte. For each memory request the unit adds the sign-extended 16-bit displacement to the base register to form the effective address. It then picks the byte lane inside the addressed word. Byte offset 0 within a word is the most significant byte, on data bits 31:24. Byte offset 3 is the least significant byte, on bits 7:0.

Stores produce the write data and a per-byte write-enable mask. Loads pass a whole word through unchanged, or take one byte and place it at the low end of the result with sign or zero extension. A word access whose address is not a multiple of four raises an error flag and performs no memory action.

A request is taken on a rising clock edge while `req_valid` is high. In the following cycle the unit drives the address, write enables, write data and read strobe from registers. The memory answers combinationally on `mem_rdata` in that same cycle, and the unit forms the load result from that data.

Top module: `lsu_be`

## Requirements
- R1: For every accepted request with a recognised memory opcode, `mem_addr` equals base plus the 16-bit displacement sign-extended to 32 bits, modulo 2^32. It appears in the cycle after acceptance.
- R2: Opcode 35 (word load) at an aligned address asserts `mem_rd` and `load_valid` and returns `mem_rdata` unchanged on `load_result`.
- R3: Opcode 43 (word store) at an aligned address drives `mem_we` = 4'b1111 and `mem_wdata` = the store operand.
- R4: Opcode 32 (signed byte load) selects byte lane k = address bits 1:0, taken from `mem_rdata` bits [31-8k -: 8]. It returns that byte in bits 7:0 with bit 7 copied into bits 31:8.
- R5: Opcode 36 (unsigned byte load) selects the same lane as R4 and returns it with bits 31:8 cleared.
- R6: Opcode 40 (byte store) puts bits 7:0 of the store operand on all four byte lanes of `mem_wdata`. It asserts only `mem_we[3-k]`, where k = address bits 1:0.
- R7: A word load or word store whose address bits 1:0 are nonzero asserts `align_err`. It keeps `mem_we` at zero and `mem_rd` and `load_valid` low.
- R8: A cycle with `req_valid` low, or any other opcode value, produces no write enable, no read strobe, no `load_valid` and no `align_err` in the following cycle. `load_result` is zero whenever `load_valid` is low.
- R9: While reset is asserted and after its release, before any request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| opcode | input | 6 | Operation code (32, 35, 36, 40, 43) |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_val | input | 32 | Store operand register |
| mem_rdata | input | 32 | Word read from memory at `mem_addr` |
| mem_addr | output | 32 | Effective byte address |
| mem_rd | output | 1 | Read strobe for a valid load |
| mem_we | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data |
| align_err | output | 1 | Misaligned word access flag |
| load_valid | output | 1 | `load_result` carries a load result |
| load_result | output | 32 | Extended load data for the register file |

## Verification
The bench applies a request while the clock is low. The request is accepted on the next rising edge, and address, enables, write data, read strobe and the error flag all appear in that cycle from registers. `load_result` follows from `mem_rdata` through logic only, so every result is due exactly one edge after the request. The bench's memory model answers combinationally from the driven address. It samples all outputs at the falling edge after the accepting rising edge, and it checks the idle state one edge after every gap in the requests.

// File: rtl/lsu_be.sv
module lsu_be #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [5:0]    opcode,
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] disp,
  input  logic [DW-1:0] store_val,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic [DW/8-1:0] mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          align_err,
  output logic          load_valid,
  output logic [DW-1:0] load_result
);
  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);
  localparam logic [5:0] OP_LB  = 6'd32;
  localparam logic [5:0] OP_LW  = 6'd35;
  localparam logic [5:0] OP_LBU = 6'd36;
  localparam logic [5:0] OP_SB  = 6'd40;
  localparam logic [5:0] OP_SW  = 6'd43;

  wire [AW-1:0] ea    = base + {{(AW-OW){disp[OW-1]}}, disp};
  wire [LW-1:0] lane  = ea[LW-1:0];
  wire is_word  = (opcode == OP_LW) || (opcode == OP_SW);
  wire is_byte  = (opcode == OP_LB) || (opcode == OP_LBU) || (opcode == OP_SB);
  wire is_mem   = req_valid && (is_word || is_byte);
  wire misal    = is_mem && is_word && (lane != '0);
  wire is_load  = (opcode == OP_LW) || (opcode == OP_LB) || (opcode == OP_LBU);

  logic          word_q, sext_q;
  logic [LW-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_rd     <= 1'b0;
      mem_we     <= '0;
      mem_wdata  <= '0;
      align_err  <= 1'b0;
      load_valid <= 1'b0;
      word_q     <= 1'b0;
      sext_q     <= 1'b0;
      lane_q     <= '0;
    end else begin
      align_err  <= misal;
      mem_rd     <= is_mem && is_load && !misal;
      load_valid <= is_mem && is_load && !misal;
      mem_we     <= '0;
      if (is_mem) begin
        mem_addr <= ea;
        lane_q   <= lane;
        word_q   <= is_word;
        sext_q   <= (opcode == OP_LB);
        if (opcode == OP_SW && !misal) begin
          mem_we    <= '1;
          mem_wdata <= store_val;
        end else if (opcode == OP_SB) begin
          mem_we    <= NB'(1) << (NB - 1 - int'(lane));
          mem_wdata <= {NB{store_val[7:0]}};
        end
      end
    end
  end

  wire [DW-1:0] shifted = mem_rdata >> (8 * (NB - 1 - int'(lane_q)));
  wire [7:0]    pick    = shifted[7:0];

  always_comb begin
    if (!load_valid)
      load_result = '0;
    else if (word_q)
      load_result = mem_rdata;
    else
      load_result = {{(DW-8){sext_q & pick[7]}}, pick};
  end
endmodule

// File: rtl/lsu_be_chk.sv
module lsu_be_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic [DW/8-1:0] mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          align_err,
  input logic          load_valid,
  input logic [DW-1:0] load_result
);
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (mem_we == '0 && !load_valid && !mem_rd)); // R7
  AST_ERR_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (mem_addr[1:0] != 2'b00)); // R7
  AST_WE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> (mem_we == '1 || $countones(mem_we) == 1)); // R6
  AST_SB_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mem_we) == 1) |-> (mem_wdata[31:24] == mem_wdata[7:0] &&
      mem_wdata[23:16] == mem_wdata[7:0] && mem_wdata[15:8] == mem_wdata[7:0])); // R6
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> (mem_we == '0)); // R8
  AST_IDLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> (load_result == '0)); // R8
endmodule

bind lsu_be lsu_be_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_we(mem_we), .mem_wdata(mem_wdata), .align_err(align_err),
  .load_valid(load_valid), .load_result(load_result)
);

// File: tb/lsu_be_test.sv
`timescale 1ns/1ps
module lsu_be_test;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [5:0] opcode = 0;
  logic [31:0] base = 0, store_val = 0, mem_rdata;
  logic [15:0] disp = 0;
  logic [31:0] mem_addr, mem_wdata, load_result;
  logic mem_rd, align_err, load_valid;
  logic [3:0] mem_we;
  logic ovr_en = 0;
  logic [31:0] ovr_word = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] memword(input logic [31:0] a);
    return ({2'b00, a[31:2]} * 32'h9E3779B1) ^ 32'h5A3C_0F81;
  endfunction

  assign mem_rdata = ovr_en ? ovr_word : memword(mem_addr);

  lsu_be uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .base(base), .disp(disp), .store_val(store_val), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .align_err(align_err), .load_valid(load_valid), .load_result(load_result));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic v, input logic [5:0] op, input logic [31:0] b,
                     input logic [15:0] d, input logic [31:0] sv);
    logic [31:0] ea, w, res;
    logic [1:0] k;
    logic word, mem, err, ld;
    logic [3:0] we;
    logic [7:0] by;
    req_valid = v; opcode = op; base = b; disp = d; store_val = sv;
    ea = b + {{16{d[15]}}, d};
    k = ea[1:0];
    word = (op == 35 || op == 43);
    mem = v && (word || op == 32 || op == 36 || op == 40);
    err = mem && word && k != 0;
    ld = mem && !err && (op == 35 || op == 32 || op == 36);
    we = 4'h0;
    if (mem && op == 43 && !err) we = 4'hF;
    if (mem && op == 40) we = 4'b1000 >> k;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    w = ovr_en ? ovr_word : memword(ea);
    by = 8'(w >> (8 * (3 - k)));
    res = 0;
    if (ld) res = (op == 35) ? w : (op == 32) ? {{24{by[7]}}, by} : {24'h0, by};
    if (mem) chk("R1 addr", mem_addr, ea);
    chk(err ? "R7 align_err" : "R8 align_err", {31'h0, align_err}, {31'h0, err});
    chk(op == 40 ? "R6 we" : op == 43 ? "R3 we" : "R8 we", {28'h0, mem_we}, {28'h0, we});
    if (we == 4'hF) chk("R3 wdata", mem_wdata, sv);
    if (mem && op == 40) chk("R6 wdata", mem_wdata, {4{sv[7:0]}});
    chk("R8 load_valid", {31'h0, load_valid}, {31'h0, ld});
    chk("R2 mem_rd", {31'h0, mem_rd}, {31'h0, ld});
    chk(op == 32 ? "R4 result" : op == 36 ? "R5 result" : "R2 result", load_result, res);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [7];
    ops = '{6'd32, 6'd35, 6'd36, 6'd40, 6'd43, 6'd0, 6'd8};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset we", {28'h0, mem_we}, 32'h0);
    chk("R9 reset addr", mem_addr, 32'h0);
    chk("R9 reset flags", {29'h0, align_err, load_valid, mem_rd}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after reset result", load_result, 32'h0);
    chk("R9 after reset we", {28'h0, mem_we}, 32'h0);
    // directed corners
    ovr_en = 1; ovr_word = 32'h80_7F_01_FE;
    run(1, 32, 32'h1000, 16'h0000, 0);      // R4 lane 0 negative
    run(1, 32, 32'h1000, 16'h0001, 0);      // R4 lane 1 positive
    run(1, 36, 32'h1000, 16'h0000, 0);      // R5 no extension
    run(1, 36, 32'h1003, 16'h0000, 0);      // R5 lane 3
    run(1, 35, 32'h1000, 16'hFFFC, 0);      // R2 negative displacement
    run(1, 35, 32'h1002, 16'h0000, 0);      // R7 misaligned load
    ovr_en = 0;
    run(1, 43, 32'h2001, 16'h0000, 32'hDEADBEEF); // R7 misaligned store
    run(1, 43, 32'h0000_0004, 16'h8000, 32'h12345678); // R1 wrap, R3
    for (int k = 0; k < 4; k++) run(1, 40, 32'h3000 + k, 16'h0, 32'hAABBCC5D); // R6 each lane
    run(0, 43, 32'h4000, 16'h0, 32'h1);     // R8 no request
    run(1, 6'd8, 32'h4000, 16'h0, 32'h1);   // R8 unknown opcode
    run(1, 35, 32'hFFFF_FFF0, 16'h0010, 0); // R1 overflow to zero
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      op = ops[$urandom % 7];
      run(($urandom % 8) != 0, op, $urandom, 16'($urandom), $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule